// File: doc/BRIEF.md
# Multiplexed Latency Timing Channel

This block links two timing-model stages that advance independently. Model time on the channel is counted in transfers, not clock cycles. Each transfer is a tagged word: a valid bit plus a data payload. An invalid word means there was no activity in that model cycle, but it still counts as one model cycle. One set of channel logic is shared by several model instances. They take turns in a fixed round-robin order, on the sending side and on the receiving side.

The channel holds its latency in model time, whatever the physical delay. It does this by starting out already holding `LAT*NINST` invalid words, laid out in round-robin instance order. So the n-th word sent for an instance comes out as that instance's (n+LAT)-th received word. This stays true however many clock cycles the writer and reader run apart, or leave idle between transfers.

Both sides name the instance they are serving. A transfer whose instance does not match the expected turn is refused, and a sticky error flag goes up.

Top module: `mlt_channel`

## Requirements
- R1: After reset, `canSend` and `canRecv` are 1, `recvValid` is 0, `errFlag` is 0, and both expected-instance outputs are 0.
- R2: The first `LAT*NINST` words received after reset are invalid (`recvValid`=0), with `expRecvInst` stepping 0,1,...,NINST-1,0,...
- R3: A word accepted as the n-th send for instance k is presented as the (n+LAT)-th receive for instance k, with its valid bit and, when valid, its data unchanged.
- R4: A word sent with valid bit 0 is received with `recvValid`=0, and still uses up one model cycle for its instance.
- R5: Each accepted send advances `expSendInst` by one, modulo NINST. Each accepted receive does the same for `expRecvInst`. Refused transfers leave them unchanged.
- R6: `canSend` is 0 exactly when `DEPTH=(LAT+1)*NINST` words are held. A send while full is ignored.
- R7: `canRecv` is 0 and `recvValid` is 0 when no word is held. A receive while empty is ignored.
- R8: A send or receive whose instance differs from the expected one is ignored, and it sets `errFlag`. The flag stays 1 until reset.
- R9: A send and a receive accepted in the same clock cycle leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sendEn | input | 1 | Send request |
| sendInst | input | INST_W | Instance the sender is serving |
| sendValid | input | 1 | Tag of sent word (1 = activity) |
| sendData | input | DW | Payload of sent word |
| recvEn | input | 1 | Receive (dequeue) request |
| recvInst | input | INST_W | Instance the receiver is serving |
| recvValid | output | 1 | Tag of the word at the head |
| recvData | output | DW | Payload of the word at the head |
| canSend | output | 1 | Space available for one word |
| canRecv | output | 1 | A word is waiting |
| expSendInst | output | INST_W | Instance expected on the next send |
| expRecvInst | output | INST_W | Instance expected on the next receive |
| errFlag | output | 1 | Sticky instance-mismatch flag |

## Verification
The main test runs sends and receives in lockstep, using a mixed sequence of valid and invalid words with distinct payloads. It first checks that the preloaded invalid words drain out. It then checks that each word comes back exactly `LAT` rounds later for the same instance, which shows up any off-by-one error in preload depth or instance order.

A send-only burst fills the channel and probes the full boundary. A receive-only drain empties it and probes the empty boundary. Refused transfers at each edge are tested to see whether they disturb the turn order or the data.

Out-of-turn instance IDs on each side show whether a mismatch is refused and flagged rather than accepted.

// File: rtl/mlt_pkg.sv
package mlt_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } mltStrobe_t;
endpackage

// File: rtl/mlt_ctrl.sv
module mlt_ctrl #(
  parameter int LAT   = 3,
  parameter int NINST = 4,
  parameter int DEPTH = (LAT + 1) * NINST,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int INST_W = $clog2(NINST)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sendEn,
  input  logic [INST_W-1:0]    sendInst,
  input  logic                 recvEn,
  input  logic [INST_W-1:0]    recvInst,
  output mlt_pkg::mltStrobe_t  strobe,
  output logic [PTR_W-1:0]     wrPtr,
  output logic [PTR_W-1:0]     rdPtr,
  output logic                 canSend,
  output logic                 canRecv,
  output logic [INST_W-1:0]    expSendInst,
  output logic [INST_W-1:0]    expRecvInst,
  output logic                 errFlag
);
  localparam int PRELOAD = LAT * NINST;

  logic [CNT_W-1:0] count;
  logic sendMatch, recvMatch, badReq;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [INST_W-1:0] bumpInst(input logic [INST_W-1:0] i);
    return (i == INST_W'(NINST - 1)) ? '0 : i + 1'b1;
  endfunction

  always_comb begin
    canSend     = (count != CNT_W'(DEPTH));
    canRecv     = (count != '0);
    sendMatch   = (sendInst == expSendInst);
    recvMatch   = (recvInst == expRecvInst);
    strobe.push = sendEn && canSend && sendMatch;
    strobe.pop  = recvEn && canRecv && recvMatch;
    badReq      = (sendEn && !sendMatch) || (recvEn && !recvMatch);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count       <= CNT_W'(PRELOAD);
      wrPtr       <= PTR_W'(PRELOAD % DEPTH);
      rdPtr       <= '0;
      expSendInst <= '0;
      expRecvInst <= '0;
      errFlag     <= 1'b0;
    end else begin
      if (strobe.push && !strobe.pop) count <= count + 1'b1;
      else if (!strobe.push && strobe.pop) count <= count - 1'b1;
      if (strobe.push) begin
        wrPtr       <= bumpPtr(wrPtr);
        expSendInst <= bumpInst(expSendInst);
      end
      if (strobe.pop) begin
        rdPtr       <= bumpPtr(rdPtr);
        expRecvInst <= bumpInst(expRecvInst);
      end
      if (badReq) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/mlt_store.sv
module mlt_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rstN,
  input  mlt_pkg::mltStrobe_t strobe,
  input  logic [PTR_W-1:0]    wrPtr,
  input  logic [PTR_W-1:0]    rdPtr,
  input  logic                sendValid,
  input  logic [DW-1:0]       sendData,
  output logic                headValid,
  output logic [DW-1:0]       headData
);
  logic [DEPTH-1:0] slotValid;
  logic [DW-1:0]    slotData [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) slotValid <= '0;
    else if (strobe.push) slotValid[wrPtr] <= sendValid;
  end

  always_ff @(posedge clk) begin
    if (strobe.push) slotData[wrPtr] <= sendData;
  end

  assign headValid = slotValid[rdPtr];
  assign headData  = slotData[rdPtr];
endmodule

// File: rtl/mlt_channel.sv
module mlt_channel #(
  parameter int LAT    = 3,
  parameter int NINST  = 4,
  parameter int DW     = 8,
  parameter int INST_W = $clog2(NINST)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sendEn,
  input  logic [INST_W-1:0] sendInst,
  input  logic              sendValid,
  input  logic [DW-1:0]     sendData,
  input  logic              recvEn,
  input  logic [INST_W-1:0] recvInst,
  output logic              recvValid,
  output logic [DW-1:0]     recvData,
  output logic              canSend,
  output logic              canRecv,
  output logic [INST_W-1:0] expSendInst,
  output logic [INST_W-1:0] expRecvInst,
  output logic              errFlag
);
  localparam int DEPTH = (LAT + 1) * NINST;
  localparam int PTR_W = $clog2(DEPTH);

  mlt_pkg::mltStrobe_t strobe;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic headValid;

  mlt_ctrl #(.LAT(LAT), .NINST(NINST), .DEPTH(DEPTH), .PTR_W(PTR_W),
             .INST_W(INST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sendEn(sendEn), .sendInst(sendInst),
    .recvEn(recvEn), .recvInst(recvInst), .strobe(strobe),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .canSend(canSend), .canRecv(canRecv),
    .expSendInst(expSendInst), .expRecvInst(expRecvInst), .errFlag(errFlag)
  );

  mlt_store #(.DEPTH(DEPTH), .DW(DW), .PTR_W(PTR_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .sendValid(sendValid), .sendData(sendData),
    .headValid(headValid), .headData(recvData)
  );

  assign recvValid = canRecv && headValid;
endmodule

// File: rtl/mlt_channel_chk.sv
module mlt_channel_chk #(
  parameter int NINST  = 4,
  parameter int INST_W = $clog2(NINST)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sendEn,
  input logic [INST_W-1:0] sendInst,
  input logic              recvEn,
  input logic [INST_W-1:0] recvInst,
  input logic              recvValid,
  input logic              canSend,
  input logic              canRecv,
  input logic [INST_W-1:0] expSendInst,
  input logic [INST_W-1:0] expRecvInst,
  input logic              errFlag
);
  function automatic logic [INST_W-1:0] nxt(input logic [INST_W-1:0] i);
    return (i == INST_W'(NINST - 1)) ? '0 : i + 1'b1;
  endfunction

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag); // R8
  AST_BAD_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (sendEn && sendInst != expSendInst) |=> (errFlag && $stable(expSendInst))); // R8
  AST_RR_SEND: assert property (@(posedge clk) disable iff (!rstN)
    (sendEn && canSend && sendInst == expSendInst) |=> (expSendInst == nxt($past(expSendInst)))); // R5
  AST_RR_RECV: assert property (@(posedge clk) disable iff (!rstN)
    (recvEn && canRecv && recvInst == expRecvInst) |=> (expRecvInst == nxt($past(expRecvInst)))); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!canSend && !recvEn) |=> !canSend); // R6
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !canRecv |-> !recvValid); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!canRecv && !sendEn) |=> !canRecv); // R7
endmodule

bind mlt_channel mlt_channel_chk #(.NINST(NINST), .INST_W(INST_W)) uChk (
  .clk(clk), .rstN(rstN), .sendEn(sendEn), .sendInst(sendInst),
  .recvEn(recvEn), .recvInst(recvInst), .recvValid(recvValid),
  .canSend(canSend), .canRecv(canRecv), .expSendInst(expSendInst),
  .expRecvInst(expRecvInst), .errFlag(errFlag)
);

// File: tb/sim_mlt_channel.sv
`timescale 1ns/1ps
module sim_mlt_channel;
  localparam int LAT = 3, NINST = 4, DW = 8, IW = 2;
  localparam int PRE = LAT * NINST;
  localparam int DEPTH = (LAT + 1) * NINST;
  localparam int NV = 24;
  localparam logic [8:0] VEC [NV] = '{
    9'h111, 9'h022, 9'h133, 9'h144, 9'h055, 9'h166, 9'h077, 9'h188,
    9'h199, 9'h0AA, 9'h1BB, 9'h1CC, 9'h10D, 9'h01E, 9'h12F, 9'h130,
    9'h041, 9'h152, 9'h163, 9'h074, 9'h185, 9'h196, 9'h0A7, 9'h1B8};

  logic clk = 0, rstN = 0;
  logic sendEn = 0, sendValid = 0, recvEn = 0;
  logic [IW-1:0] sendInst = 0, recvInst = 0;
  logic [DW-1:0] sendData = 0;
  logic recvValid, canSend, canRecv, errFlag;
  logic [DW-1:0] recvData;
  logic [IW-1:0] expSendInst, expRecvInst;
  int nChk = 0, nBad = 0;

  always #2.5 clk = ~clk;

  mlt_channel #(.LAT(LAT), .NINST(NINST), .DW(DW)) u0 (
    .clk(clk), .rstN(rstN), .sendEn(sendEn), .sendInst(sendInst),
    .sendValid(sendValid), .sendData(sendData), .recvEn(recvEn),
    .recvInst(recvInst), .recvValid(recvValid), .recvData(recvData),
    .canSend(canSend), .canRecv(canRecv), .expSendInst(expSendInst),
    .expRecvInst(expRecvInst), .errFlag(errFlag));

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic se, input int si, input logic sv,
                       input int sd, input logic re, input int ri);
    @(negedge clk);
    sendEn = se; sendInst = IW'(si); sendValid = sv; sendData = DW'(sd);
    recvEn = re; recvInst = IW'(ri);
    #1;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; sendEn = 0; recvEn = 0;
    @(negedge clk); @(negedge clk); rstN = 1;
  endtask

  initial begin
    #(5.0 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    doReset();
    #1;
    check("R1 canSend", canSend, 1);
    check("R1 canRecv", canRecv, 1);
    check("R1 recvValid", recvValid, 0);
    check("R1 errFlag", errFlag, 0);
    check("R1 expSendInst", expSendInst, 0);
    check("R1 expRecvInst", expRecvInst, 0);

    // lockstep table walk: send and receive together each step
    for (int s = 0; s < NV; s++) begin
      drive(1, s % NINST, VEC[s][8], VEC[s][7:0], 1, s % NINST);
      check("R5 expRecvInst", expRecvInst, s % NINST);
      check("R9 canSend", canSend, 1);
      if (s < PRE) check("R2 preload invalid", recvValid, 0);
      else begin
        check(VEC[s-PRE][8] ? "R3 valid tag" : "R4 invalid tag",
              recvValid, VEC[s-PRE][8]);
        if (VEC[s-PRE][8]) check("R3 data", recvData, VEC[s-PRE][7:0]);
      end
    end

    // fill: PRE held, DEPTH-PRE more sends fit
    for (int i = 0; i < DEPTH - PRE; i++) begin
      drive(1, i % NINST, 1, 'hA0 + i, 0, 0);
      check("R6 space before full", canSend, 1);
      check("R5 expSendInst", expSendInst, i % NINST);
    end
    drive(1, 0, 1, 'hEE, 0, 0);
    check("R6 full", canSend, 0);

    // drain everything
    for (int i = 0; i < DEPTH; i++) begin
      drive(0, 0, 0, 0, 1, i % NINST);
      check("R7 not empty", canRecv, 1);
      if (i < PRE) begin
        check("R3 drain tag", recvValid, VEC[NV-PRE+i][8]);
        if (VEC[NV-PRE+i][8]) check("R3 drain data", recvData, VEC[NV-PRE+i][7:0]);
      end else begin
        check("R6 drain tag", recvValid, 1);
        check("R6 full send ignored", recvData, 'hA0 + i - PRE);
      end
    end
    drive(0, 0, 0, 0, 1, 0);
    check("R7 empty", canRecv, 0);
    check("R7 empty no valid", recvValid, 0);
    drive(1, 0, 1, 'h5A, 0, 0);
    check("R7 empty recv ignored", expRecvInst, 0);
    drive(0, 0, 0, 0, 1, 0);
    check("R7 head after empty", recvValid, 1);
    check("R7 head data", recvData, 'h5A);
    check("R8 no error yet", errFlag, 0);

    // wrong instance IDs
    doReset();
    drive(1, 2, 1, 'h77, 0, 0);
    drive(0, 0, 0, 0, 1, 1);
    check("R8 errFlag set", errFlag, 1);
    check("R8 send ignored", expSendInst, 0);
    drive(0, 0, 0, 0, 0, 0);
    check("R8 recv ignored", expRecvInst, 0);
    check("R8 errFlag held", errFlag, 1);
    check("R8 head still preload", recvValid, 0);
    doReset();
    #1;
    check("R1 errFlag cleared", errFlag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule